// File: doc/BRIEF.md
# AUX Channel Request Buffer and Sequencer

This block sits between software and a byte-wide AUX link serializer. Software fills a 144-byte command buffer through a data register. First comes a four-byte request header: an address nibble and a read flag, the middle address byte, the low address byte, and the length minus one. For writes the payload follows. Software then sets a go bit in a transaction register. The block checks the request against the buffer capacity and the mode's length limit. If the request passes, it hands the loaded bytes to the serializer one at a time with a valid/ready handshake, then waits for the reply.

Reply bytes of a read are stored back into the buffer from index 0. Software reads them through the same data register after selecting read mode. Every outcome is reported in an 8-bit status word: success, a rejected request, a reply timeout, a link refusal, a wrong reply count or a physical-layer error. Any set status bit raises the interrupt output. A control register holds an enable bit and a soft reset. The reply timeout and a retry limit are 16-bit registers that reset to 0xFFFF.

Register addresses on `reg_addr`: 0 control (bit 0 enable, bit 1 soft reset), 1 data, 2 transaction (bit 0 go, bit 1 I2C mode, bit 2 no-send-address, bit 3 no-send-stop), 3 timeout, 4 retry limit, 5 status.

Top module: `aux_req_seq`

## Requirements
- R1: A data write (address 1) with bit 31 set and bit 30 clear stores `reg_wdata[7:0]` at index 0 and leaves the pointer at 1. Without bit 31 it stores at the pointer, which then increments. Once 144 bytes are held, a further write is dropped and marks the buffer overflowed, and a later go is rejected with status bit 1.
- R2: A launched request sends the buffer bytes in index order 0 to N-1, N being the loaded byte count. A byte is held stable while `tx_valid` is high and `tx_ready` is low, and `tx_last` marks byte N-1.
- R3: Byte 0 bit 4 set selects a read, which must load exactly 4 bytes. A write must load 4 + (byte 3 + 1) bytes. Any other count rejects the go with status bit 1 (0x02) and sends nothing.
- R4: The data length (byte 3 + 1) is limited to 16 for a native request and to 128 when the I2C mode bit is set. A longer request is rejected with status 0x02.
- R5: A data write with bits 31 and 30 set enters read mode at index 0. The first data read then returns 0 as a dummy. Each later read returns the byte at the pointer in bits [15:8] and increments the pointer.
- R6: A transaction write with bit 0 set launches only while idle and enabled. Its bits 1 to 3 drive `tx_i2c`, `tx_no_addr` and `tx_no_stop`, which stay unchanged for the whole transaction. Transaction and data writes made during a transaction are ignored.
- R7: When `rx_end` arrives in the reply wait, exactly one status bit is set, in this priority order: `rx_phy_err` sets bit 7; `rx_nack` sets bit 5 in I2C mode and bit 3 otherwise; `rx_defer` sets bit 6 in I2C mode and bit 3 otherwise; a clean end sets bit 0. A status write (address 5) ANDs the status with `reg_wdata[7:0]`, so writing 0 clears it. `irq` is high while any status bit is set.
- R8: If the reply wait sees neither a byte nor `rx_end` for timeout + 1 consecutive cycles, status bit 2 (0x04) is set. The block returns to idle and the buffer is left unchanged.
- R9: Reply bytes of a read are stored from index 0 in arrival order. A byte on the `rx_end` cycle is dropped. If a clean end follows a number of bytes different from byte 3 + 1, bit 4 (0x10) is set instead of bit 0.
- R10: After reset the control register reads 0, the timeout and retry limit read 0xFFFF, and the status reads 0. A control write with bit 1 set clears the status and the pointer and aborts any transaction.
- R11: Status bit 0 never rises while a byte is still pending on the serializer or before `rx_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data pointer) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| irq | output | 1 | High while any status bit is set |
| tx_valid | output | 1 | Request byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_byte | output | 8 | Request byte |
| tx_last | output | 1 | Offered byte is the last of the request |
| tx_i2c | output | 1 | I2C-over-AUX framing |
| tx_no_addr | output | 1 | Framing flag: address phase suppressed |
| tx_no_stop | output | 1 | Framing flag: stop suppressed |
| rx_valid | input | 1 | Reply byte strobe |
| rx_byte | input | 8 | Reply byte |
| rx_end | input | 1 | Reply complete; the flags below are sampled with it |
| rx_nack | input | 1 | Reply refused |
| rx_defer | input | 1 | Reply deferred |
| rx_phy_err | input | 1 | Physical-layer error on the reply |

## Verification
A wrong pointer shows up at once in the serializer byte order and in the readback, where the bytes come out shifted or a header byte appears where reply data was expected. A sequencer stuck in the wrong state either keeps `tx_valid` high past the last byte, or ignores a reply so that a timeout status appears where done was expected. A wrong length check turns a boundary request, 16 native or 128 I2C data bytes, into a rejected one, or lets one byte too many go out; either way the status register shows it on the first poll after the go. Framing flags that change in the middle of a transaction, or a second launch, appear as extra bytes or changed flags at the serializer within a few cycles.

// File: rtl/aux_req_seq.sv
module aux_req_seq #(
  parameter int DEPTH      = 144,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  output logic        tx_i2c,
  output logic        tx_no_addr,
  output logic        tx_no_stop,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic        rx_nack,
  input  logic        rx_defer,
  input  logic        rx_phy_err
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT} st_t;

  st_t            st;
  logic [7:0]     mem [DEPTH];
  logic [PW-1:0]  ptr, tx_idx, rx_cnt;
  logic           ovf, dummy, rd_q, en_q, rst_q;
  logic [3:0]     tc_q;
  logic [15:0]    tmo_q, lim_q, tmr;
  logic [8:0]     len_q;
  logic [7:0]     stat, sset;

  wire idle    = (st == S_IDLE);
  wire wr_ctrl = reg_wr && reg_addr == 3'd0;
  wire wr_data = reg_wr && reg_addr == 3'd1;
  wire wr_tc   = reg_wr && reg_addr == 3'd2;
  wire wr_stat = reg_wr && reg_addr == 3'd5;
  wire rd_data = reg_rd && reg_addr == 3'd1;
  wire clr     = rst_q || (wr_ctrl && reg_wdata[1]);

  wire [8:0] len1 = {1'b0, mem[3]} + 9'd1;
  wire       req_rd = mem[0][4];
  wire [8:0] need = req_rd ? 9'd4 : 9'd4 + len1;
  wire [8:0] lim  = reg_wdata[1] ? 9'(I2C_MAX) : 9'(NATIVE_MAX);
  wire       bad  = ovf || (len1 > lim) || (9'(ptr) != need);
  wire       launch = wr_tc && reg_wdata[0] && idle && en_q && !clr;

  wire [PW-1:0] wbase = reg_wdata[31] ? '0 : ptr;
  wire          dstore = wr_data && idle && !clr && !reg_wdata[30] && (wbase < FULL);
  wire          rstore = (st == S_WAIT) && rd_q && rx_valid && !rx_end && (rx_cnt < FULL);

  assign tx_valid   = (st == S_TX);
  assign tx_byte    = (tx_idx < FULL) ? mem[tx_idx] : 8'h00;
  assign tx_last    = tx_valid && (tx_idx == ptr - 1'b1);
  assign tx_i2c     = tc_q[1];
  assign tx_no_addr = tc_q[2];
  assign tx_no_stop = tc_q[3];
  assign irq        = |stat;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = {30'd0, rst_q, en_q};
      3'd1: reg_rdata = (dummy || ptr >= FULL) ? 32'd0 : {16'd0, mem[ptr], 8'd0};
      3'd2: reg_rdata = {28'd0, tc_q};
      3'd3: reg_rdata = {16'd0, tmo_q};
      3'd4: reg_rdata = {16'd0, lim_q};
      3'd5: reg_rdata = {24'd0, stat};
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    sset = '0;
    if (launch && bad) sset[1] = 1'b1;
    if (st == S_WAIT) begin
      if (rx_end) begin
        if (rx_phy_err)                     sset[7] = 1'b1;
        else if (rx_nack)                   sset[tc_q[1] ? 5 : 3] = 1'b1;
        else if (rx_defer)                  sset[tc_q[1] ? 6 : 3] = 1'b1;
        else if (rd_q && 9'(rx_cnt) != len_q) sset[4] = 1'b1;
        else                                sset[0] = 1'b1;
      end else if (!rx_valid && tmr == 16'd0) begin
        sset[2] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dstore) mem[wbase] <= reg_wdata[7:0];
    else if (rstore) mem[rx_cnt] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rst_q <= 1'b0;
      tmo_q <= 16'hFFFF;
      lim_q <= 16'hFFFF;
      tc_q  <= '0;
    end else begin
      if (wr_ctrl) {rst_q, en_q} <= reg_wdata[1:0];
      if (reg_wr && reg_addr == 3'd3) tmo_q <= reg_wdata[15:0];
      if (reg_wr && reg_addr == 3'd4) lim_q <= reg_wdata[15:0];
      if (wr_tc && idle) tc_q <= reg_wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else if (clr) stat <= '0;
    else stat <= (wr_stat ? (stat & reg_wdata[7:0]) : stat) | sset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; tx_idx <= '0; rx_cnt <= '0;
      ovf <= 1'b0; dummy <= 1'b0; rd_q <= 1'b0; tmr <= '0; len_q <= '0;
    end else if (clr) begin
      st <= S_IDLE; ptr <= '0; ovf <= 1'b0; dummy <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (launch && !bad) begin
            st <= S_TX; tx_idx <= '0; rx_cnt <= '0; rd_q <= req_rd; len_q <= len1;
          end else if (wr_data) begin
            if (reg_wdata[30]) begin
              ptr <= '0; dummy <= 1'b1; ovf <= 1'b0;
            end else begin
              dummy <= 1'b0;
              if (reg_wdata[31]) ovf <= 1'b0;
              if (wbase < FULL) ptr <= wbase + 1'b1;
              else ovf <= 1'b1;
            end
          end else if (rd_data) begin
            if (dummy) dummy <= 1'b0;
            else if (ptr < FULL) ptr <= ptr + 1'b1;
          end
        end
        S_TX: if (tx_ready) begin
          if (tx_idx == ptr - 1'b1) begin
            st <= S_WAIT; tmr <= tmo_q;
          end else tx_idx <= tx_idx + 1'b1;
        end
        S_WAIT: begin
          if (rx_end) st <= S_IDLE;
          else if (rx_valid) begin
            tmr <= tmo_q;
            if (rx_cnt < FULL) rx_cnt <= rx_cnt + 1'b1;
          end else if (tmr == 16'd0) st <= S_IDLE;
          else tmr <= tmr - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module aux_req_seq_chk #(parameter int PW = 8, parameter int DEPTH = 144) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_byte,
  input logic          tx_i2c,
  input logic          tx_no_addr,
  input logic          tx_no_stop,
  input logic          rx_valid,
  input logic          rx_end,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [7:0]    stat,
  input logic [PW-1:0] ptr
);
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
  assert_frame_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && $past(tx_valid) |-> $stable({tx_i2c, tx_no_addr, tx_no_stop}));
  assert_done_late_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> !tx_valid && $past(rx_end));
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && reg_wdata[1] |=> stat == 8'd0 && ptr == '0);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));
  assert_timeout_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> !tx_valid && !$past(rx_valid) && !$past(rx_end));
endmodule

bind aux_req_seq aux_req_seq_chk #(.PW(PW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .tx_i2c(tx_i2c), .tx_no_addr(tx_no_addr),
  .tx_no_stop(tx_no_stop), .rx_valid(rx_valid), .rx_end(rx_end),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .stat(stat), .ptr(ptr));

// File: tb/aux_req_seq_tb.sv
`timescale 1ns/1ps
module aux_req_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, tx_valid, tx_last, tx_i2c, tx_no_addr, tx_no_stop;
  logic tx_ready = 1;
  logic [7:0] tx_byte;
  logic rx_valid = 0, rx_end = 0, rx_nack = 0, rx_defer = 0, rx_phy_err = 0;
  logic [7:0] rx_byte = 0;

  int checks = 0, fails = 0, cyc = 0, tx_total = 0;
  logic [7:0] tx_log [512];
  logic [2:0] last_fl = 0;
  logic stall = 0;

  always #2 clk = ~clk;

  aux_req_seq dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) begin
      tx_log[tx_total % 512] <= tx_byte;
      last_fl <= {tx_no_stop, tx_no_addr, tx_i2c};
      tx_total <= tx_total + 1;
    end
  end
  always @(negedge clk) tx_ready <= stall ? (cyc % 3 == 0) : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic hdr(input logic [19:0] a, input logic r, input int len1);
    wr(1, 32'h8000_0000 | {28'd0, r, a[19:16]});
    wr(1, {24'd0, a[15:8]});
    wr(1, {24'd0, a[7:0]});
    wr(1, 32'(len1 - 1) & 32'hFF);
  endtask

  task automatic fill(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) wr(1, {24'd0, seed + 8'(i)});
  endtask

  task automatic wait_tx(input int target);
    while (tx_total < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic reply(input int n, input logic [31:0] b, input logic [2:0] fl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1; rx_byte = b[8*i +: 8];
      @(negedge clk); rx_valid = 0;
    end
    @(negedge clk); rx_end = 1; {rx_phy_err, rx_defer, rx_nack} = fl;
    @(negedge clk); rx_end = 0; {rx_phy_err, rx_defer, rx_nack} = 0;
    @(negedge clk);
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    logic [31:0] d;
    peek(5, d);
    check(req, d, {24'd0, exp});
    check({req, " irq"}, {31'd0, irq}, {31'd0, |exp});
    wr(5, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    peek(0, d); check("R10 ctrl reset", d, 0);
    peek(3, d); check("R10 timeout reset", d, 32'hFFFF);
    peek(4, d); check("R10 limit reset", d, 32'hFFFF);
    peek(5, d); check("R10 status reset", d, 0);
    hdr(20'h00010, 1, 4);
    wr(2, 1);
    repeat (5) @(negedge clk);
    check("R6 go ignored while disabled", tx_total, 0);
    wr(0, 1); wr(3, 50);
  endtask

  task automatic t_native_write;
    int base = tx_total;
    logic [31:0] d;
    hdr(20'h12345, 0, 3);
    wr(1, 32'hAA); wr(1, 32'hBB); wr(1, 32'hCC);
    stall = 1;
    wr(2, 1);
    wait_tx(base + 7);
    stall = 0;
    check("R2 count", tx_total - base, 7);
    check("R2 b0", tx_log[base % 512], 8'h01);
    check("R2 b1", tx_log[(base + 1) % 512], 8'h23);
    check("R2 b2", tx_log[(base + 2) % 512], 8'h45);
    check("R2 b3", tx_log[(base + 3) % 512], 8'h02);
    check("R2 b6", tx_log[(base + 6) % 512], 8'hCC);
    peek(5, d); check("R11 no done before reply", d, 0);
    reply(0, 0, 3'b000);
    status_is("R7 clean native", 8'h01);
  endtask

  task automatic t_i2c_read;
    int base = tx_total;
    logic [31:0] d;
    hdr(20'hA0050, 1, 4);
    wr(2, 32'hF);
    wait_tx(base + 4);
    check("R3 read sends header only", tx_total - base, 4);
    check("R6 framing flags", last_fl, 3'b111);
    reply(4, 32'h44332211, 3'b000);
    status_is("R9 full read", 8'h01);
    wr(1, 32'hC000_0000);
    rd(1, d); check("R5 dummy first", d, 0);
    rd(1, d); check("R5 R9 byte0", d, 32'h1100);
    rd(1, d); check("R5 R9 byte1", d, 32'h2200);
    rd(1, d); rd(1, d); check("R5 R9 byte3", d, 32'h4400);
  endtask

  task automatic t_errors;
    int base = tx_total;
    hdr(20'h00100, 1, 4); wr(2, 3); wait_tx(base + 4);
    reply(2, 32'h0000_5566, 3'b000);
    status_is("R9 short reply", 8'h10);
    hdr(20'h00100, 0, 1); fill(1, 8'h9); wr(2, 1); wait_tx(base + 9);
    reply(0, 0, 3'b001); status_is("R7 native nack", 8'h08);
    hdr(20'h00100, 0, 1); fill(1, 8'h9); wr(2, 3); wait_tx(base + 14);
    reply(0, 0, 3'b001); status_is("R7 i2c nack", 8'h20);
    hdr(20'h00100, 0, 1); fill(1, 8'h9); wr(2, 3); wait_tx(base + 19);
    reply(0, 0, 3'b010); status_is("R7 i2c defer", 8'h40);
    hdr(20'h00100, 0, 1); fill(1, 8'h9); wr(2, 1); wait_tx(base + 24);
    reply(0, 0, 3'b111); status_is("R7 phy error priority", 8'h80);
  endtask

  task automatic t_limits;
    int base = tx_total;
    hdr(20'h0, 0, 17); fill(17, 0); wr(2, 1);
    repeat (5) @(negedge clk);
    status_is("R4 native 17 rejected", 8'h02);
    check("R4 nothing sent", tx_total - base, 0);
    hdr(20'h0, 0, 16); fill(16, 0); wr(2, 1); wait_tx(base + 20);
    reply(0, 0, 0); status_is("R4 native 16 accepted", 8'h01);
    hdr(20'h0, 0, 129); fill(129, 0); wr(2, 3);
    repeat (5) @(negedge clk);
    status_is("R4 i2c 129 rejected", 8'h02);
    hdr(20'h0, 0, 128); fill(128, 8'h40); wr(2, 3); wait_tx(base + 152);
    check("R4 i2c 128 last byte", tx_log[(base + 151) % 512], 8'h40 + 8'd127);
    reply(0, 0, 0); status_is("R4 i2c 128 accepted", 8'h01);
  endtask

  task automatic t_capacity;
    int base = tx_total;
    hdr(20'h0, 0, 128); fill(146, 0); wr(2, 3);
    repeat (5) @(negedge clk);
    status_is("R1 overflow rejected", 8'h02);
    hdr(20'h0, 1, 4); fill(1, 0); wr(2, 1);
    repeat (5) @(negedge clk);
    status_is("R3 read with extra byte rejected", 8'h02);
    check("R3 nothing sent", tx_total - base, 0);
  endtask

  task automatic t_timeout;
    int base = tx_total;
    logic [31:0] d;
    wr(3, 20);
    hdr(20'h3_0000, 1, 2); wr(2, 1); wait_tx(base + 4);
    repeat (12) @(negedge clk);
    peek(5, d); check("R8 not yet expired", d, 0);
    repeat (20) @(negedge clk);
    status_is("R8 timeout", 8'h04);
    wr(1, 32'hC000_0000);
    rd(1, d); rd(1, d); check("R8 buffer untouched", d, 32'h1300);
    wr(3, 50);
  endtask

  task automatic t_busy_go;
    int base = tx_total;
    logic [31:0] d;
    hdr(20'h0, 0, 2); fill(2, 8'h70);
    stall = 1;
    wr(2, 1);
    wr(2, 32'hF);
    wr(1, 32'h8000_00EE);
    wait_tx(base + 6);
    stall = 0;
    check("R6 flags kept", last_fl, 3'b000);
    check("R6 data write ignored", tx_log[base % 512], 8'h00);
    peek(2, d); check("R6 trans reg unchanged", d, 1);
    reply(0, 0, 0);
    repeat (10) @(negedge clk);
    check("R6 single launch", tx_total - base, 6);
    status_is("R6 done once", 8'h01);
  endtask

  task automatic t_soft_reset;
    logic [31:0] d;
    hdr(20'h0, 1, 4); fill(1, 0); wr(2, 1);
    fill(3, 8'h11);
    wr(0, 3); wr(0, 1);
    peek(5, d); check("R10 status cleared", d, 0);
    wr(1, 32'h5A);
    wr(1, 32'hC000_0000);
    rd(1, d); rd(1, d); check("R10 R1 pointer cleared", d, 32'h5A00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_native_write;
    t_i2c_read;
    t_errors;
    t_limits;
    t_capacity;
    t_timeout;
    t_busy_go;
    t_soft_reset;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule